// File: doc/BRIEF.md
# Trailing Zero Count Unit

This unit measures how many zero bits sit below the lowest set bit of an operand. An operand of 16, 32 or 64 bits is chosen by a size code, and bits of the input word above the chosen size play no part in the result. When no bit of the operand is set, the count equals the operand size, as if a one stood just past the top bit.

Along with the count, the unit gives two status flags. A carry flag reports an all-zero operand. A zero flag reports a zero count, which happens when bit 0 is set. Four further flags have no defined meaning for this operation, so they are held at zero to keep the outputs deterministic. The result goes to a register and appears one clock after a valid strobe, zero-extended to 64 bits.

Top module: `tzc_unit`

## Requirements
- R1: For a nonzero operand, out_count equals the number of consecutive clear bits counted upward from bit 0, up to the first set bit.
- R2: For an all-zero operand, out_count equals the operand size: 16, 32 or 64.
- R3: The in_size codes are 2'b00 for 16 bits, 2'b01 for 32 bits, 2'b10 for 64 bits, and 2'b11 also for 64 bits.
- R4: Input bits at or above the selected operand size do not affect out_count, out_carry or out_zero.
- R5: out_carry is 1 exactly when the selected operand is zero.
- R6: out_zero is 1 exactly when out_count is zero, which means bit 0 of the operand is set.
- R7: out_count is zero-extended to 64 bits, so every bit above the count value is 0 in all modes.
- R8: out_ovf, out_sign, out_parity and out_aux are always 0.
- R9: A result and out_valid=1 appear on the first rising edge after in_valid=1 is sampled. After a rising edge with in_valid=0, out_valid is 0 and the count and flags keep their previous values.
- R10: A synchronous active-high rst clears out_valid, out_count, out_carry and out_zero to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 64 | Operand word; only the low bits selected by in_size are used |
| in_size | input | 2 | Operand size code |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_count | output | 64 | Trailing zero count, zero-extended |
| out_carry | output | 1 | Set when the operand is zero |
| out_zero | output | 1 | Set when the count is zero |
| out_ovf | output | 1 | Undefined flag, held at 0 |
| out_sign | output | 1 | Undefined flag, held at 0 |
| out_parity | output | 1 | Undefined flag, held at 0 |
| out_aux | output | 1 | Undefined flag, held at 0 |

## Verification
The assertions assume that in_valid and in_size carry known values on every clock after reset. They also assume that the registered size code matches the operand that produced the stored count, so the bound and carry checks can compare the count with the operand size. The stimulus sets every input at a falling edge, starting before reset is released. It uses all four size codes, including the 64-bit alias, and fills the ignored upper bits with random values so that any leak from them would show in the result.

// File: rtl/tzc_pkg.sv
package tzc_pkg;
   localparam int unsigned OPND_MAX_W = 64;

   typedef enum logic [1:0] {
      SZ_HALF  = 2'b00,
      SZ_WORD  = 2'b01,
      SZ_DWORD = 2'b10,
      SZ_ALIAS = 2'b11
   } size_code_e;

   // Operand width in bits selected by a size code.
   function automatic int unsigned width_of(input logic [1:0] code);
      case (code)
         SZ_HALF: return 16;
         SZ_WORD: return 32;
         default: return 64;
      endcase
   endfunction
endpackage

// File: rtl/tzc_operand_pad.sv
// Forces every bit at or above the selected size to one and adds a guard
// one above the top bit, so a single scan covers all sizes and the zero case.
module tzc_operand_pad
   import tzc_pkg::*;
#(
   parameter int unsigned DATA_W = 64
) (
   input  logic [DATA_W-1:0] data,
   input  logic [1:0]        size,
   output logic [DATA_W:0]   padded,
   output logic              opnd_zero
);
   logic [DATA_W-1:0] keep;

   always_comb begin
      for (int i = 0; i < DATA_W; i++) begin
         keep[i] = (i < int'(width_of(size)));
      end
   end

   assign padded    = {1'b1, (data & keep) | ~keep};
   assign opnd_zero = ~|(data & keep);
endmodule

// File: rtl/tzc_scan.sv
// Finds the index of the lowest set bit of a vector that always has at least one bit set.
module tzc_scan #(
   parameter int unsigned VEC_W = 65,
   localparam int unsigned CNT_W = $clog2(VEC_W)
) (
   input  logic [VEC_W-1:0] vec,
   output logic [CNT_W-1:0] idx
);
   if (VEC_W < 2) begin : g_bad_width
      $error("tzc_scan: VEC_W must be at least 2");
   end

   always_comb begin
      idx = '0;
      for (int i = VEC_W - 1; i >= 0; i--) begin
         if (vec[i]) idx = CNT_W'(i);
      end
   end
endmodule

// File: rtl/tzc_unit.sv
module tzc_unit
   import tzc_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   localparam int unsigned CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   input  logic [1:0]        in_size,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_count,
   output logic              out_carry,
   output logic              out_zero,
   output logic              out_ovf,
   output logic              out_sign,
   output logic              out_parity,
   output logic              out_aux
);
   if (DATA_W != OPND_MAX_W) begin : g_bad_width
      $error("tzc_unit: DATA_W must equal the largest operand size");
   end

   logic [DATA_W:0]  padded;
   logic             opnd_zero;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] cnt_q;
   logic             carry_q, zflag_q, valid_q;
   logic [1:0]       size_q;

   tzc_operand_pad #(.DATA_W(DATA_W)) u_pad (
      .data      (in_data),
      .size      (in_size),
      .padded    (padded),
      .opnd_zero (opnd_zero)
   );

   tzc_scan #(.VEC_W(DATA_W + 1)) u_scan (
      .vec (padded),
      .idx (cnt_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         cnt_q   <= '0;
         carry_q <= 1'b0;
         zflag_q <= 1'b0;
         size_q  <= SZ_HALF;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            cnt_q   <= cnt_d;
            carry_q <= opnd_zero;
            zflag_q <= (cnt_d == '0);
            size_q  <= in_size;
         end
      end
   end

   assign out_valid  = valid_q;
   assign out_count  = DATA_W'(cnt_q);
   assign out_carry  = carry_q;
   assign out_zero   = zflag_q;
   assign out_ovf    = 1'b0;
   assign out_sign   = 1'b0;
   assign out_parity = 1'b0;
   assign out_aux    = 1'b0;

   // R2 / R5: the carry flag appears only together with a count equal to the size
   a_r5_carry_width: assert property (@(posedge clk) disable iff (rst)
      (out_valid && out_carry) |-> (out_count == DATA_W'(width_of(size_q))));
   // R1 / R2: the count never exceeds the operand size
   a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_count <= DATA_W'(width_of(size_q))));
   // R6: the zero flag agrees with the stored count
   a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_zero == (out_count == '0)));
   // R9: one-cycle latency of the valid strobe
   a_r9_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
   a_r9_valid_drops: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
   // R9: results hold while no operand arrives
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_count) && $stable(out_carry) && $stable(out_zero)));
endmodule

// File: tb/tzc_unit_test.sv
`timescale 1ns/1ps
module tzc_unit_test;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [63:0] in_data = '0;
   logic [1:0]  in_size = 2'b00;
   logic        out_valid, out_carry, out_zero, out_ovf, out_sign, out_parity, out_aux;
   logic [63:0] out_count;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   logic [63:0] exp_count = '0;
   logic        exp_carry = 1'b0, exp_zero = 1'b0, exp_valid = 1'b0;
   string       exp_tag = "R10";

   always #2 clk = ~clk;

   tzc_unit uut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_size(in_size),
      .out_valid(out_valid), .out_count(out_count), .out_carry(out_carry), .out_zero(out_zero),
      .out_ovf(out_ovf), .out_sign(out_sign), .out_parity(out_parity), .out_aux(out_aux)
   );

   function automatic int size_bits(input logic [1:0] s);
      if (s == 2'b00) return 16;
      if (s == 2'b01) return 32;
      return 64;
   endfunction

   function automatic int ref_count(input logic [63:0] d, input int w);
      int n = 0;
      while (n < w && d[n] == 1'b0) n++;
      return n;
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Compare outputs against the model, then apply the next stimulus.
   task automatic step(input string tag, input logic v, input logic [63:0] d, input logic [1:0] s);
      check("R9 valid", {63'd0, out_valid}, {63'd0, exp_valid});
      check(exp_tag, out_count, exp_count);
      check("R5 carry", {63'd0, out_carry}, {63'd0, exp_carry});
      check("R6 zero", {63'd0, out_zero}, {63'd0, exp_zero});
      check("R8 undefined flags", {60'd0, out_ovf, out_sign, out_parity, out_aux}, 64'd0);
      in_valid = v; in_data = d; in_size = s;
      exp_valid = v;
      if (v) begin
         int w = size_bits(s);
         int c = ref_count(d, w);
         exp_count = 64'(c);
         exp_carry = (c == w);
         exp_zero  = (c == 0);
         exp_tag   = tag;
      end else begin
         exp_tag = "R9 hold";
      end
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 valid", {63'd0, out_valid}, 64'd0);
      check("R10 count", out_count, 64'd0);
      check("R10 flags", {62'd0, out_carry, out_zero}, 64'd0);
      rst = 1'b0;
      @(negedge clk);
      for (int s = 0; s < 4; s++) begin
         int w = size_bits(2'(s));
         // R2: all-zero operand gives the size, with ones above it (R4)
         step("R2 zero operand", 1'b1, 64'd0, 2'(s));
         step("R4 zero low, junk high", 1'b1, (w == 64) ? 64'd0 : ~((64'd1 << w) - 1), 2'(s));
         // R1: single set bit at every position
         for (int b = 0; b < w; b++)
            step("R1 single bit", 1'b1, 64'd1 << b, 2'(s));
         // R4 / R7 / R3: random operands with random upper bits
         for (int k = 0; k < 40; k++) begin
            logic [63:0] r = {$urandom, $urandom};
            r = r & ~((64'd1 << ($urandom % 64)) - 1);
            step((s == 3) ? "R3 alias size" : "R4 random", 1'b1, r, 2'(s));
         end
         // R6: bit 0 set
         step("R6 bit0", 1'b1, 64'hFFFF_0000_0000_0001, 2'(s));
         // R9: idle cycles hold the result
         step("R1 before idle", 1'b1, 64'h0000_0000_0000_0100, 2'(s));
         step("R9 idle", 1'b0, {$urandom, $urandom}, 2'(s));
         step("R9 idle", 1'b0, 64'd0, 2'(s));
      end
      // R3: same operand under each size code
      step("R3 size 16", 1'b1, 64'h0001_0000_0000_0000, 2'b00);
      step("R3 size 32", 1'b1, 64'h0001_0000_0000_0000, 2'b01);
      step("R3 size 64", 1'b1, 64'h0001_0000_0000_0000, 2'b10);
      step("R3 size alias", 1'b1, 64'h0001_0000_0000_0000, 2'b11);
      step("R7 final", 1'b0, 64'd0, 2'b00);
      // R10: reset in mid-run clears the outputs
      rst = 1'b1;
      @(posedge clk); @(negedge clk);
      check("R10 valid after reset", {63'd0, out_valid}, 64'd0);
      check("R10 count after reset", out_count, 64'd0);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule